// File: doc/BRIEF.md
# Full-Duplex PAUSE Receive Timer

This block sits on the receive side of one full-duplex Ethernet MAC port and acts on IEEE 802.3x flow control. Upstream logic has already parsed each frame and checked its CRC. At the end of each frame this block gets a strobe together with the frame's EtherType, the MAC Control opcode, the 16-bit pause quanta and a CRC-good flag. When the frame is a valid PAUSE request, the quanta is loaded into a down-counter. While that counter is non-zero, the block holds off the local transmit MAC.

The counter steps down once per slot-time tick and releases the transmitter when it reaches zero. A frame that is already going out when the request arrives is allowed to finish. The countdown does not advance while the transmitter reports busy, so the pause time begins at the end of that frame. If the transmitter is idle, the pause time begins at once. A new PAUSE request that arrives during an active pause replaces the remaining count. Every good-CRC MAC Control frame is flagged for dropping, so that it is never forwarded.

Top module: `pause_rx_timer`

## Requirements
- R1: After reset, `tx_pause` is 0, and `ctrl_drop` is 0 whenever `frame_end` is low.
- R2: A valid PAUSE request sets `tx_pause` to 1 from the cycle after the `frame_end` strobe when its quanta is non-zero. A valid PAUSE request is `frame_end`=1 with `crc_ok`=1, `ether_type`=16'h8808 and `opcode`=16'h0001.
- R3: A frame with `crc_ok`=0 or with `ether_type` other than 16'h8808 leaves `tx_pause` and the remaining count unchanged, and gives `ctrl_drop`=0.
- R4: `ctrl_drop` is 1 in the `frame_end` cycle of every frame with `crc_ok`=1 and `ether_type`=16'h8808, whatever its opcode. Opcodes other than 16'h0001 leave `tx_pause` unchanged.
- R5: While `tx_busy` is 0, each `slot_tick` cycle lowers the count by one. A quanta of Q therefore drops `tx_pause` right after the Q-th tick.
- R6: While `tx_busy` is 1, `slot_tick` does not lower the count, so the countdown starts once the frame in flight ends.
- R7: A valid PAUSE request during an active pause loads its own quanta in place of the remaining count.
- R8: A valid PAUSE request with quanta 0 clears `tx_pause` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle strobe at the end of a received frame |
| crc_ok | input | 1 | Frame CRC is good (valid with `frame_end`) |
| ether_type | input | 16 | Parsed EtherType/length field |
| opcode | input | 16 | Parsed MAC Control opcode |
| quanta | input | 16 | Parsed pause quanta |
| tx_busy | input | 1 | Local transmitter is sending a frame |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| tx_pause | output | 1 | Hold off new transmissions (XOFF) when 1 |
| ctrl_drop | output | 1 | Discard the current MAC Control frame |

## Verification
A wrong count shows up at `tx_pause` as a release that comes one or more ticks too early or too late. That error only becomes visible when the counter reaches zero, so the bench counts ticks exactly, up to the release, including reloads that replace a larger remaining count. A countdown that advances while the transmitter is busy also shows up only as an early release, so the bench holds `tx_busy` high across more ticks than the quanta. A wrong match on type, opcode or CRC shows up in the same cycle on `ctrl_drop`, and one cycle later on `tx_pause`.

// File: rtl/pause_rx_timer.sv
module pause_rx_timer #(
  parameter int QW = 16,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          crc_ok,
  input  logic [15:0]   ether_type,
  input  logic [15:0]   opcode,
  input  logic [QW-1:0] quanta,
  input  logic          tx_busy,
  input  logic          slot_tick,
  output logic          tx_pause,
  output logic          ctrl_drop
);
  logic [QW-1:0] cnt;
  logic is_ctrl, is_pause, step;

  assign is_ctrl   = frame_end && crc_ok && (ether_type == CTRL_TYPE);
  assign is_pause  = is_ctrl && (opcode == PAUSE_OP);
  assign step      = slot_tick && !tx_busy && (cnt != '0);
  assign ctrl_drop = is_ctrl;
  assign tx_pause  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (is_pause) cnt <= quanta;
    else if (step)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pause_rx_timer_chk.sv
module pause_rx_timer_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end,
  input logic          crc_ok,
  input logic [15:0]   ether_type,
  input logic [15:0]   opcode,
  input logic [QW-1:0] quanta,
  input logic          tx_busy,
  input logic          slot_tick,
  input logic          tx_pause,
  input logic          ctrl_drop,
  input logic [QW-1:0] cnt
);
  logic hit;
  assign hit = frame_end && crc_ok && ether_type == 16'h8808 && opcode == 16'h0001;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit && quanta != '0 |=> tx_pause);
  p_zero_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit && quanta == '0 |=> !tx_pause);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt == $past(quanta));
  p_drop_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_drop |-> frame_end && crc_ok && ether_type == 16'h8808);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && tx_busy |=> $stable(cnt));
  p_tick_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && slot_tick && !tx_busy && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !slot_tick |=> $stable(cnt));
  p_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !tx_pause);
endmodule

bind pause_rx_timer pause_rx_timer_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .crc_ok(crc_ok),
  .ether_type(ether_type), .opcode(opcode), .quanta(quanta),
  .tx_busy(tx_busy), .slot_tick(slot_tick), .tx_pause(tx_pause),
  .ctrl_drop(ctrl_drop), .cnt(cnt)
);

// File: tb/pause_rx_timer_tb.sv
`timescale 1ns/1ps
module pause_rx_timer_tb;
  logic clk = 0, rst_n = 0;
  logic frame_end = 0, crc_ok = 0, tx_busy = 0, slot_tick = 0;
  logic [15:0] ether_type = 0, opcode = 0, quanta = 0;
  logic tx_pause, ctrl_drop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pause_rx_timer u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .crc_ok(crc_ok),
    .ether_type(ether_type), .opcode(opcode), .quanta(quanta),
    .tx_busy(tx_busy), .slot_tick(slot_tick), .tx_pause(tx_pause),
    .ctrl_drop(ctrl_drop)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drives one frame-end cycle; checks drop mid-cycle, returns at next negedge
  task automatic send(input logic [15:0] t, input logic [15:0] op,
                      input logic [15:0] q, input logic ok, input logic exp_drop,
                      input string req);
    frame_end = 1; crc_ok = ok; ether_type = t; opcode = op; quanta = q;
    #5 check(req, ctrl_drop, exp_drop);
    @(negedge clk);
    frame_end = 0; crc_ok = 0;
  endtask

  task automatic tick();
    slot_tick = 1;
    @(negedge clk);
    slot_tick = 0;
  endtask

  task automatic t_reset();
    check("R1 tx_pause after reset", tx_pause, 0);
    check("R1 ctrl_drop idle", ctrl_drop, 0);
  endtask

  task automatic t_basic();
    send(16'h8808, 16'h0001, 16'd3, 1, 1, "R4 drop on pause");
    check("R2 pause asserted", tx_pause, 1);
    tick(); check("R5 after tick 1", tx_pause, 1);
    @(negedge clk); check("R5 no tick holds", tx_pause, 1);
    tick(); check("R5 after tick 2", tx_pause, 1);
    tick(); check("R5 release after tick 3", tx_pause, 0);
  endtask

  task automatic t_ignored();
    send(16'h8808, 16'h0001, 16'd5, 0, 0, "R3 bad crc no drop");
    check("R3 bad crc no pause", tx_pause, 0);
    send(16'h0800, 16'h0001, 16'd5, 1, 0, "R3 other type no drop");
    check("R3 other type no pause", tx_pause, 0);
    send(16'h8808, 16'h0002, 16'd5, 1, 1, "R4 other opcode dropped");
    check("R4 other opcode no pause", tx_pause, 0);
    send(16'h8808, 16'h0001, 16'd2, 1, 1, "R4 drop");
    send(16'h8808, 16'h0001, 16'd0, 0, 0, "R3 bad crc during pause");
    send(16'h8808, 16'h0003, 16'd0, 1, 1, "R4 other opcode during pause");
    tick(); check("R3 count kept at 2", tx_pause, 1);
    tick(); check("R3 release after 2", tx_pause, 0);
  endtask

  task automatic t_busy();
    tx_busy = 1;
    send(16'h8808, 16'h0001, 16'd2, 1, 1, "R4 drop");
    check("R2 pause while busy", tx_pause, 1);
    for (int i = 0; i < 4; i++) tick();
    check("R6 busy ticks ignored", tx_pause, 1);
    tx_busy = 0;
    tick(); check("R6 first tick after busy", tx_pause, 1);
    tick(); check("R6 release after busy", tx_pause, 0);
  endtask

  task automatic t_reload();
    send(16'h8808, 16'h0001, 16'd5, 1, 1, "R4 drop");
    tick(); tick();
    send(16'h8808, 16'h0001, 16'd2, 1, 1, "R4 drop reload");
    tick(); check("R7 reloaded count 1 left", tx_pause, 1);
    tick(); check("R7 reloaded release", tx_pause, 0);
    send(16'h8808, 16'h0001, 16'd1, 1, 1, "R4 drop");
    send(16'h8808, 16'h0001, 16'd3, 1, 1, "R4 drop");
    tick(); tick(); check("R7 longer reload holds", tx_pause, 1);
    tick(); check("R7 longer reload release", tx_pause, 0);
  endtask

  task automatic t_zero();
    send(16'h8808, 16'h0001, 16'd4, 1, 1, "R4 drop");
    check("R2 pause on", tx_pause, 1);
    send(16'h8808, 16'h0001, 16'd0, 1, 1, "R4 drop zero");
    check("R8 zero quanta releases", tx_pause, 0);
    tick(); check("R8 stays released", tx_pause, 0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignored();
    t_busy();
    t_reload();
    t_zero();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule